// File: doc/BRIEF.md
# Dependency-Aware Cache Insertion Controller

This block keeps the replacement state for every set of a set-associative shared last-level cache. Each way of each set holds a valid flag and a 2-bit re-reference prediction. The value 0 means the line is expected to be reused soon. The value 3 means reuse is expected to be distant. Each access names a set, says whether it hit and, for a hit, which way. It also carries the dependency class of the task data that caused it: read-only, write-only or read-write. Tag and data arrays sit outside the block; the block only decides which way to replace and what prediction the new line starts with.

On a hit, the block promotes the line by setting its prediction to 0. On a miss, it first fills the lowest-index invalid way of the set. When the set is full, it ages every way of the set by the same amount, so that at least one way reaches distant reuse, and evicts the lowest-index way that holds 3. The prediction given to the new line is taken from a table that software programs, with one entry per dependency class. Each entry can also turn on a bimodal mode. In that mode, a free-running pseudo-random sequence compared against a programmable threshold decides line by line whether the table value or the distant value is used.

Top module: `dep_insert_repl`

## Requirements
- R1: Every cycle with `accValid` high produces exactly one cycle of `respValid` high on the next cycle. A cycle without an access produces `respValid` low on the next cycle.
- R2: A hit answers with `respHit`=1, `respWay` equal to `accHitWay`, `respFill`=0 and `respRrpv`=0. The prediction of that way becomes 0, and no other way changes.
- R3: A miss to a set with at least one invalid way fills the lowest-index invalid way, marks it valid and answers with `respFill`=1. No other way's prediction changes.
- R4: A miss to a full set first adds (3 - highest prediction in the set) to every way of the set. It then evicts the lowest-index way whose prediction is 3, answers with `respFill`=0, and writes the insertion prediction to the evicted way.
- R5: The insertion prediction on a miss is the table entry for the request's class. `accClass` encodings are 0 read-only, 1 write-only and 2 read-write; code 3 uses the read-write entry. The value is reported on `respRrpv`.
- R6: A cycle with `cfgWe` high and `cfgAddr` 0, 1 or 2 writes that class's entry. `cfgData[1:0]` sets the prediction and `cfgData[2]` sets the bimodal enable. `cfgAddr` 3 writes the 9-bit threshold from `cfgData[8:0]`. The new setting applies to accesses from the next cycle on.
- R7: For a class with bimodal mode enabled, a miss inserts the table value when the pseudo-random value is below the threshold, and inserts 3 otherwise. The pseudo-random value is an 8-bit register that resets to 1 and advances on every clock: it shifts right by one, and when the bit shifted out was 1 the result is XORed with 0xB8. A threshold of 0 therefore always inserts 3, and a threshold of 256 always inserts the table value.
- R8: After reset every way is invalid, no response is pending, the table holds read-only→2, write-only→3 and read-write→1 with bimodal mode off, and the threshold is 0.
- R9: An access changes only the state of the set it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| accValid | input | 1 | Access present this cycle |
| accSet | input | 4 | Set index of the access |
| accHit | input | 1 | 1 if the access hit |
| accHitWay | input | 2 | Way that hit (used only when accHit=1) |
| accClass | input | 2 | Dependency class of the request |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Configuration entry select |
| cfgData | input | 9 | Configuration write data |
| respValid | output | 1 | Response present |
| respHit | output | 1 | Response belongs to a hit |
| respWay | output | 2 | Way promoted, filled or evicted |
| respFill | output | 1 | Miss filled an invalid way |
| respRrpv | output | 2 | Prediction now held by respWay |

## Verification
Every response is due exactly one clock after the access that caused it, because the state and the response registers both load on the same edge. The bench drives each access on a falling edge. It computes the expected way, fill flag and prediction from its own model at that moment, using the model's copy of the pseudo-random value before the edge. It then samples the outputs on the next falling edge. Configuration writes and model updates are applied only after that edge, so back-to-back accesses to the same set see the state left by the previous access, and idle cycles are checked for a low `respValid` one edge later.

// File: rtl/dep_ins_pkg.sv
package dep_ins_pkg;
  localparam int RRPV_W   = 2;
  localparam int CLASS_W  = 2;
  localparam int NUM_CLS  = 3;
  localparam int LFSR_W   = 8;
  localparam int CFG_W    = LFSR_W + 1;
  localparam logic [RRPV_W-1:0] RRPV_NEAR    = '0;
  localparam logic [RRPV_W-1:0] RRPV_DISTANT = '1;

  localparam logic [CLASS_W-1:0] DEP_RD  = 2'd0;
  localparam logic [CLASS_W-1:0] DEP_WR  = 2'd1;
  localparam logic [CLASS_W-1:0] DEP_RW  = 2'd2;
  localparam logic [CLASS_W-1:0] DEP_RSV = 2'd3;

  localparam logic [1:0] CFG_THR_ADDR = 2'd3;

  typedef struct packed {
    logic respLoad;
    logic hitUpd;
    logic fillUpd;
    logic evictUpd;
  } insStrobe_t;
endpackage

// File: rtl/ins_lfsr.sv
module ins_lfsr #(
  parameter int W = 8,
  parameter logic [W-1:0] TAPS = 8'hB8
) (
  input  logic         clk,
  input  logic         rstN,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= W'(1);
    else if (q[0]) q <= (q >> 1) ^ TAPS;
    else q <= q >> 1;
  end
endmodule

// File: rtl/ins_ctrl.sv
module ins_ctrl
  import dep_ins_pkg::*;
(
  input  logic       accValid,
  input  logic       accHit,
  input  logic       setHasInvalid,
  output insStrobe_t strobe
);
  always_comb begin
    strobe.respLoad = accValid;
    strobe.hitUpd   = accValid && accHit;
    strobe.fillUpd  = accValid && !accHit && setHasInvalid;
    strobe.evictUpd = accValid && !accHit && !setHasInvalid;
  end
endmodule

// File: rtl/ins_datapath.sv
module ins_datapath
  import dep_ins_pkg::*;
#(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SET_W-1:0]   accSet,
  input  logic [WAY_W-1:0]   accHitWay,
  input  logic [CLASS_W-1:0] accClass,
  input  logic               cfgWe,
  input  logic [1:0]         cfgAddr,
  input  logic [CFG_W-1:0]   cfgData,
  input  logic [LFSR_W-1:0]  lfsrVal,
  input  insStrobe_t         strobe,
  output logic               setHasInvalid,
  output logic               respValid,
  output logic               respHit,
  output logic [WAY_W-1:0]   respWay,
  output logic               respFill,
  output logic [RRPV_W-1:0]  respRrpv
);
  logic [RRPV_W-1:0] rrpvQ [NUM_SETS][NUM_WAYS];
  logic [NUM_WAYS-1:0] validQ [NUM_SETS];
  logic [RRPV_W-1:0] tblRrpvQ [NUM_CLS];
  logic tblBimQ [NUM_CLS];
  logic [CFG_W-1:0] thrQ;

  logic [RRPV_W-1:0] row [NUM_WAYS];
  logic [RRPV_W-1:0] agedRow [NUM_WAYS];
  logic [RRPV_W-1:0] maxVal, ageDelta, insVal;
  logic [WAY_W-1:0] invWay, victimWay;
  logic [CLASS_W-1:0] clsIdx;
  logic belowThr;

  always_comb begin
    for (int w = 0; w < NUM_WAYS; w++) row[w] = rrpvQ[accSet][w];
  end

  always_comb begin
    setHasInvalid = 1'b0;
    invWay = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (!validQ[accSet][w]) begin
        setHasInvalid = 1'b1;
        invWay = WAY_W'(w);
      end
    end
  end

  always_comb begin
    maxVal = RRPV_NEAR;
    for (int w = 0; w < NUM_WAYS; w++)
      if (row[w] > maxVal) maxVal = row[w];
  end

  assign ageDelta = RRPV_DISTANT - maxVal;

  generate
    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_age
      assign agedRow[g] = row[g] + ageDelta;
    end
  endgenerate

  always_comb begin
    victimWay = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--)
      if (row[w] == maxVal) victimWay = WAY_W'(w);
  end

  assign clsIdx   = (accClass == DEP_RSV) ? DEP_RW : accClass;
  assign belowThr = {1'b0, lfsrVal} < thrQ;
  assign insVal   = (tblBimQ[clsIdx] && !belowThr) ? RRPV_DISTANT : tblRrpvQ[clsIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        validQ[s] <= '0;
        for (int w = 0; w < NUM_WAYS; w++) rrpvQ[s][w] <= RRPV_DISTANT;
      end
    end else if (strobe.hitUpd) begin
      rrpvQ[accSet][accHitWay] <= RRPV_NEAR;
    end else if (strobe.fillUpd) begin
      validQ[accSet][invWay] <= 1'b1;
      rrpvQ[accSet][invWay]  <= insVal;
    end else if (strobe.evictUpd) begin
      for (int w = 0; w < NUM_WAYS; w++)
        rrpvQ[accSet][w] <= (WAY_W'(w) == victimWay) ? insVal : agedRow[w];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tblRrpvQ[DEP_RD] <= 2'd2;
      tblRrpvQ[DEP_WR] <= 2'd3;
      tblRrpvQ[DEP_RW] <= 2'd1;
      for (int c = 0; c < NUM_CLS; c++) tblBimQ[c] <= 1'b0;
      thrQ <= '0;
    end else if (cfgWe) begin
      if (cfgAddr == CFG_THR_ADDR) begin
        thrQ <= cfgData;
      end else begin
        tblRrpvQ[cfgAddr] <= cfgData[RRPV_W-1:0];
        tblBimQ[cfgAddr]  <= cfgData[RRPV_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respWay   <= '0;
      respFill  <= 1'b0;
      respRrpv  <= '0;
    end else begin
      respValid <= strobe.respLoad;
      respHit   <= strobe.hitUpd;
      respFill  <= strobe.fillUpd;
      if (strobe.hitUpd) begin
        respWay  <= accHitWay;
        respRrpv <= RRPV_NEAR;
      end else if (strobe.fillUpd) begin
        respWay  <= invWay;
        respRrpv <= insVal;
      end else if (strobe.evictUpd) begin
        respWay  <= victimWay;
        respRrpv <= insVal;
      end
    end
  end
endmodule

// File: rtl/dep_insert_repl.sv
module dep_insert_repl
  import dep_ins_pkg::*;
#(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               accValid,
  input  logic [SET_W-1:0]   accSet,
  input  logic               accHit,
  input  logic [WAY_W-1:0]   accHitWay,
  input  logic [1:0]         accClass,
  input  logic               cfgWe,
  input  logic [1:0]         cfgAddr,
  input  logic [8:0]         cfgData,
  output logic               respValid,
  output logic               respHit,
  output logic [WAY_W-1:0]   respWay,
  output logic               respFill,
  output logic [1:0]         respRrpv
);
  insStrobe_t strobe;
  logic setHasInvalid;
  logic [LFSR_W-1:0] lfsrVal;

  ins_lfsr #(.W(LFSR_W), .TAPS(8'hB8)) u_lfsr (
    .clk(clk), .rstN(rstN), .q(lfsrVal)
  );

  ins_ctrl u_ctrl (
    .accValid(accValid), .accHit(accHit),
    .setHasInvalid(setHasInvalid), .strobe(strobe)
  );

  ins_datapath #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_dp (
    .clk(clk), .rstN(rstN), .accSet(accSet), .accHitWay(accHitWay),
    .accClass(accClass), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .lfsrVal(lfsrVal), .strobe(strobe), .setHasInvalid(setHasInvalid),
    .respValid(respValid), .respHit(respHit), .respWay(respWay),
    .respFill(respFill), .respRrpv(respRrpv)
  );
endmodule

// File: rtl/ins_checker.sv
module ins_checker #(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input logic             clk,
  input logic             rstN,
  input logic             accValid,
  input logic [SET_W-1:0] accSet,
  input logic             accHit,
  input logic [WAY_W-1:0] accHitWay,
  input logic [1:0]       accClass,
  input logic             cfgWe,
  input logic [1:0]       cfgAddr,
  input logic [8:0]       cfgData,
  input logic             respValid,
  input logic             respHit,
  input logic [WAY_W-1:0] respWay,
  input logic             respFill,
  input logic [1:0]       respRrpv
);
  logic [WAY_W:0] fillCnt [NUM_SETS];
  logic [1:0] shTbl [3];
  logic shBim [3];
  logic [1:0] cls;
  logic [WAY_W-1:0] fillWayExp;
  logic setFull, isMiss;

  assign cls        = (accClass == 2'd3) ? 2'd2 : accClass;
  assign fillWayExp = fillCnt[accSet][WAY_W-1:0];
  assign setFull    = (fillCnt[accSet] == (WAY_W+1)'(NUM_WAYS));
  assign isMiss     = accValid && !accHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) fillCnt[s] <= '0;
      shTbl[0] <= 2'd2; shTbl[1] <= 2'd3; shTbl[2] <= 2'd1;
      for (int c = 0; c < 3; c++) shBim[c] <= 1'b0;
    end else begin
      if (isMiss && !setFull) fillCnt[accSet] <= fillCnt[accSet] + 1'b1;
      if (cfgWe && cfgAddr != 2'd3) begin
        shTbl[cfgAddr] <= cfgData[1:0];
        shBim[cfgAddr] <= cfgData[2];
      end
    end
  end

  p_resp_follows_r1: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> respValid);
  p_no_stray_resp_r1: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> !respValid);
  p_hit_echo_r2: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accHit) |=> (respHit && !respFill && respRrpv == 2'd0
                              && respWay == $past(accHitWay)));
  p_fill_order_r3: assert property (@(posedge clk) disable iff (!rstN)
    (isMiss && !setFull) |=> (respFill && respWay == $past(fillWayExp)));
  p_no_fill_full_r4: assert property (@(posedge clk) disable iff (!rstN)
    (isMiss && setFull) |=> (!respFill && !respHit));
  p_table_insert_r5: assert property (@(posedge clk) disable iff (!rstN)
    (isMiss && !shBim[cls]) |=> (respRrpv == $past(shTbl[cls])));
  p_bimodal_choice_r7: assert property (@(posedge clk) disable iff (!rstN)
    (isMiss && shBim[cls]) |=> (respRrpv == 2'd3 || respRrpv == $past(shTbl[cls])));
endmodule

bind dep_insert_repl ins_checker #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_chk (.*);

// File: tb/dep_insert_repl_test.sv
module dep_insert_repl_test;
  localparam int NS = 16;
  localparam int NW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accValid = 1'b0, accHit = 1'b0, cfgWe = 1'b0;
  logic [3:0] accSet = '0;
  logic [1:0] accHitWay = '0, accClass = '0, cfgAddr = '0;
  logic [8:0] cfgData = '0;
  logic respValid, respHit, respFill;
  logic [1:0] respWay, respRrpv;

  always #2 clk = ~clk;

  dep_insert_repl uut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accSet(accSet), .accHit(accHit),
    .accHitWay(accHitWay), .accClass(accClass), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .respValid(respValid), .respHit(respHit), .respWay(respWay),
    .respFill(respFill), .respRrpv(respRrpv)
  );

  int mR [NS][NW];
  bit mV [NS][NW];
  int tbl [3];
  bit bim [3];
  int thr;
  logic [7:0] prng;
  int nCmp = 0, nBad = 0;
  bit finished = 1'b0;

  // pseudo-random reference from R7
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prng <= 8'd1;
    else if (prng[0]) prng <= (prng >> 1) ^ 8'hB8;
    else prng <= prng >> 1;
  end

  task automatic check(string req, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin mR[s][w] = 3; mV[s][w] = 0; end
    tbl[0] = 2; tbl[1] = 3; tbl[2] = 1;
    for (int c = 0; c < 3; c++) bim[c] = 0;
    thr = 0;
  endtask

  // called on a falling edge; returns on the next falling edge
  task automatic access(int s, bit h, int w, int c);
    int ci, ins, expWay, mx, inv;
    bit expFill, useBim;
    accValid = 1'b1; accSet = 4'(s); accHit = h; accHitWay = 2'(w); accClass = 2'(c);
    ci = (c == 3) ? 2 : c;
    useBim = bim[ci];
    ins = (useBim && !(int'(prng) < thr)) ? 3 : tbl[ci];
    expFill = 0;
    if (h) begin
      expWay = w; ins = 0; mR[s][w] = 0;
    end else begin
      inv = -1;
      for (int k = NW - 1; k >= 0; k--) if (!mV[s][k]) inv = k;
      if (inv >= 0) begin
        expWay = inv; expFill = 1; mV[s][inv] = 1; mR[s][inv] = ins;
      end else begin
        mx = 0;
        for (int k = 0; k < NW; k++) if (mR[s][k] > mx) mx = mR[s][k];
        for (int k = 0; k < NW; k++) mR[s][k] += 3 - mx;
        expWay = 0;
        for (int k = NW - 1; k >= 0; k--) if (mR[s][k] == 3) expWay = k;
        mR[s][expWay] = ins;
      end
    end
    @(posedge clk); @(negedge clk);
    accValid = 1'b0;
    check("R1 respValid", int'(respValid), 1);
    check("R2 respHit", int'(respHit), int'(h));
    if (h) check("R2 hit way", int'(respWay), expWay);
    else if (expFill) check("R3 fill way", int'(respWay), expWay);
    else check("R4 victim way", int'(respWay), expWay);
    check(expFill ? "R3 fill flag" : "R4 fill flag", int'(respFill), int'(expFill));
    if (h) check("R2 promoted rrpv", int'(respRrpv), 0);
    else if (useBim) check("R7 bimodal insert", int'(respRrpv), ins);
    else check("R5 table insert", int'(respRrpv), ins);
  endtask

  task automatic idle(int n);
    accValid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      check("R1 idle respValid", int'(respValid), 0);
    end
  endtask

  task automatic cfgWrite(int a, int d);
    cfgWe = 1'b1; cfgAddr = 2'(a); cfgData = 9'(d);
    @(posedge clk); @(negedge clk);
    cfgWe = 1'b0;
    if (a == 3) thr = d;
    else begin tbl[a] = d & 3; bim[a] = (d >> 2) & 1; end
  endtask

  task automatic randomHit(int s, int c);
    int w;
    w = int'($urandom_range(NW - 1));
    while (!mV[s][w]) w = (w + 1) % NW;
    access(s, 1, w, c);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 reset respValid", int'(respValid), 0);

    // R8: default table values, read through fills of set 1
    access(1, 0, 0, 0); check("R8 default read-only", int'(respRrpv), 2);
    access(1, 0, 0, 1); check("R8 default write-only", int'(respRrpv), 3);
    access(1, 0, 0, 2); check("R8 default read-write", int'(respRrpv), 1);
    access(1, 0, 0, 3); check("R5 reserved class uses read-write", int'(respRrpv), 1);
    idle(2);

    // R3 fills in order, R2 promote, R4 aging and victim
    for (int i = 0; i < NW; i++) access(0, 0, 0, 0);
    access(0, 1, 2, 1);
    access(0, 0, 0, 0); check("R4 aged victim lowest way", int'(respWay), 0);
    access(0, 0, 0, 1);
    check("R4 second victim", int'(respWay), 1);

    // R9: a fresh set is untouched by traffic to others
    access(5, 0, 0, 2); check("R9 untouched set fills way 0", int'(respFill), 1);

    // R6: reprogram write-only entry
    cfgWrite(1, 0);
    access(6, 0, 0, 1); check("R6 new write-only value", int'(respRrpv), 0);

    // R7: bimodal extremes
    cfgWrite(0, 4 | 1);
    access(7, 0, 0, 0); check("R7 threshold 0 gives distant", int'(respRrpv), 3);
    cfgWrite(3, 256);
    access(7, 0, 0, 0); check("R7 threshold 256 gives table", int'(respRrpv), 1);
    cfgWrite(3, 100);
    idle(1);

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      int s, c, r;
      bit anyValid;
      s = int'($urandom_range(NS - 1));
      c = int'($urandom_range(3));
      r = int'($urandom_range(99));
      anyValid = 0;
      for (int k = 0; k < NW; k++) if (mV[s][k]) anyValid = 1;
      if (r < 3) cfgWrite(int'($urandom_range(3)), int'($urandom_range(511)));
      else if (r < 6) idle(1);
      else if (r < 45 && anyValid) randomHit(s, c);
      else access(s, 0, 0, c);
    end
    idle(2);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule